// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors on one chip pass 32-bit words to each other through a set of small hardware queues. A sender writes a word to a queue's data register. A receiver reads the same register to take out the oldest word. For each queue, one register reports whether the queue is full and another reports how many words it holds. All registers sit in one memory-mapped window on a simple synchronous bus. Read data is combinational and valid in the cycle that `rd_en` is high. Any side effect of the access takes place at the following clock edge.

Each processor, called a user, has its own view of the event state. This view is a status word with write-one-to-clear bits and an enable word. The enable word is changed through a set register and a clear register. Every queue has two events in these words. The new-message event sits at bit 2*m and the not-full event at bit 2*m+1. A user's interrupt line is high while any enabled status bit is set. Every register reads back, so software can save and restore the mailbox state.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, all queues are empty, every status and enable word reads zero, and every interrupt line is low.
- R2: A write to the data register of queue m (byte offset 0x040 + 4*m) appends the word. A read of that register returns the oldest word and removes it, so words come out in first-in first-out order. The count register (0x0C0 + 4*m) returns the number of stored words.
- R3: Each queue holds FIFO_DEPTH words (4 by default). The full register (0x080 + 4*m) reads 1 when the queue holds FIFO_DEPTH words and 0 otherwise. A write to a full queue is discarded and leaves the stored words unchanged.
- R4: A read of an empty queue's data register returns zero and changes neither the count nor any status bit.
- R5: An accepted write to queue m sets bit 2*m in the status word of every user. While queue m is non-empty, that bit is set again at every clock edge. If a user clears it, it therefore reads 0 for one cycle and then 1 again.
- R6: A read that takes a word from a full queue m sets bit 2*m+1 in the status word of every user. A read from a queue that is not full does not set it.
- R7: The status word of user u is at 0x104 + 0x10*u. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged. A clear wins over a set event in the same edge.
- R8: Writing 1s to the enable-set register (0x108 + 0x10*u) sets those enable bits. Writing 1s to the enable-clear register (0x10C + 0x10*u) clears them. Both addresses read back the current enable word.
- R9: Interrupt line u is high exactly when the bitwise AND of user u's status word and enable word is nonzero.
- R10: Offset 0x000 reads the constant REVISION value. Writes to it have no effect, and unmapped offsets read zero.
- R11: Events of different queues and different users are independent. Activity on one queue changes only the two status bits that belong to that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a data-register read removes a word |
| rd_data | output | 32 | Read data, valid while rd_en is high |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The bench keeps an independent model of the queues, status words and enables. It compares every read and every interrupt line against this model.

The bench drives the following cases:
- It writes five words into a four-entry queue. A design that accepts the overflow would corrupt the order of the words or show a count of 5.
- It reads an empty queue. A design that moves its pointers on this read would return stale words later.
- It clears a new-message bit while the queue still holds words. A design that fails to set the bit again would lose a pending message. A design that lets the set win over the clear would never let the bit drop.
- It checks the not-full event only on a read from a full queue. A design that raised it on every read would cause spurious interrupts.
- It checks that the two events of each queue sit at their own bit positions. A design with the positions swapped would raise interrupts that no user enabled.

// File: rtl/ipc_mbox_pkg.sv
// Package: ipc_mbox_pkg
// Purpose : shared register offsets and decode types of the mailbox.
// Assumes : byte addressing, 32-bit registers on 4-byte boundaries.
package ipc_mbox_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam logic [31:0] OFS_REV  = 32'h000;
    localparam logic [31:0] OFS_MSG  = 32'h040;
    localparam logic [31:0] OFS_FULL = 32'h080;
    localparam logic [31:0] OFS_CNT  = 32'h0C0;
    localparam logic [31:0] OFS_USR  = 32'h100;

    // Kind of register addressed by the current bus access
    typedef enum logic [2:0] {
        RK_NONE,
        RK_REV,
        RK_MSG,
        RK_FULL,
        RK_CNT,
        RK_STAT,
        RK_ESET,
        RK_ECLR
    } reg_kind_e;

endpackage

// File: rtl/ipc_mbox_fifo.sv
// Module : ipc_mbox_fifo
// Purpose: one message queue, a circular buffer of DEPTH words.
// Assumes: a push to a full queue and a pop of an empty queue are dropped;
//          head reads zero while the queue is empty.
module ipc_mbox_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = count_q;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Store accepted words
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count_q == $past(count_q)));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count_q == '0));
    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/ipc_mbox_user.sv
// Module : ipc_mbox_user
// Purpose: one user's view, with a status word, an enable word and an interrupt line.
// Assumes: bit 2*m is queue m's new-message event and bit 2*m+1 its
//          not-full event; a clear wins over a set in the same edge.
module ipc_mbox_user #(
    parameter int NQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NQ-1:0]   new_evt,
    input  logic [NQ-1:0]   nf_evt,
    input  logic [2*NQ-1:0] st_clr,
    input  logic [2*NQ-1:0] en_set,
    input  logic [2*NQ-1:0] en_clr,
    output logic [2*NQ-1:0] status,
    output logic [2*NQ-1:0] enable,
    output logic            irq
);
    localparam int SW = 2 * NQ;

    logic [SW-1:0] set_vec;
    logic [SW-1:0] status_q, enable_q;

    // Interleave the two event kinds into their bit positions
    for (genvar m = 0; m < NQ; m++) begin : g_ilv
        assign set_vec[2*m]   = new_evt[m];
        assign set_vec[2*m+1] = nf_evt[m];
    end

    // Sticky status with write-one-to-clear, and enable set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q | set_vec) & ~st_clr;
            enable_q <= (enable_q | en_set) & ~en_clr;
        end
    end

    assign status = status_q;
    assign enable = enable_q;
    assign irq    = |(status_q & enable_q);

    for (genvar b = 0; b < SW; b++) begin : g_chk
        p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[b]) |-> $past(set_vec[b]));
        p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(st_clr[b]) |-> !status_q[b]);
        p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(status_q[b]) && !$past(st_clr[b])) |-> status_q[b]);
        p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_set[b]) && !$past(en_clr[b])) |-> enable_q[b]);
    end

endmodule

// File: rtl/ipc_mailbox.sv
// Module : ipc_mailbox
// Purpose: register decode, the queue array and per-user event views.
// Assumes: one access per cycle (a write or a read, not both); read data is
//          combinational, and side effects happen at the next clock edge.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int          NUM_QUEUES = 8,
    parameter int          NUM_USERS  = 3,
    parameter int          FIFO_DEPTH = 4,
    parameter int          ADDR_W     = 9,
    parameter logic [31:0] REVISION   = 32'h0001_0200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    output logic [31:0]          rd_data,
    output logic [NUM_USERS-1:0] irq
);
    localparam int SW    = 2 * NUM_QUEUES;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [31:0]     a_w;
    reg_kind_e       sel_kind;
    logic [4:0]      sel_idx;

    logic [31:0]          head    [NUM_QUEUES];
    logic [CNT_W-1:0]     cnt     [NUM_QUEUES];
    logic [NUM_QUEUES-1:0] full_v, empty_v, push_q, pop_q, new_evt, nf_evt;
    logic [SW-1:0]        user_st [NUM_USERS];
    logic [SW-1:0]        user_en [NUM_USERS];

    assign a_w = 32'(addr);

    // Decode the byte address into a register kind and an index
    always_comb begin
        sel_kind = RK_NONE;
        sel_idx  = '0;
        if (a_w[1:0] == 2'b00) begin
            if (a_w == OFS_REV) begin
                sel_kind = RK_REV;
            end else if (a_w >= OFS_MSG && a_w < OFS_MSG + 32'(4 * NUM_QUEUES)) begin
                sel_kind = RK_MSG;
                sel_idx  = 5'((a_w - OFS_MSG) >> 2);
            end else if (a_w >= OFS_FULL && a_w < OFS_FULL + 32'(4 * NUM_QUEUES)) begin
                sel_kind = RK_FULL;
                sel_idx  = 5'((a_w - OFS_FULL) >> 2);
            end else if (a_w >= OFS_CNT && a_w < OFS_CNT + 32'(4 * NUM_QUEUES)) begin
                sel_kind = RK_CNT;
                sel_idx  = 5'((a_w - OFS_CNT) >> 2);
            end else if (a_w >= OFS_USR && a_w < OFS_USR + 32'(16 * NUM_USERS)) begin
                sel_idx = 5'((a_w - OFS_USR) >> 4);
                case (a_w[3:2])
                    2'd1:    sel_kind = RK_STAT;
                    2'd2:    sel_kind = RK_ESET;
                    2'd3:    sel_kind = RK_ECLR;
                    default: sel_kind = RK_NONE;
                endcase
            end
        end
    end

    // One queue per index, with its two event sources
    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
        assign push_q[q]  = wr_en && (sel_kind == RK_MSG) && (sel_idx == 5'(q));
        assign pop_q[q]   = rd_en && (sel_kind == RK_MSG) && (sel_idx == 5'(q));
        assign new_evt[q] = (push_q[q] && !full_v[q]) || !empty_v[q];
        assign nf_evt[q]  = pop_q[q] && full_v[q];

        ipc_mbox_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_q[q]),
            .pop   (pop_q[q]),
            .wdata (wr_data),
            .head  (head[q]),
            .count (cnt[q]),
            .full  (full_v[q]),
            .empty (empty_v[q])
        );
    end

    // One event view per user
    for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
        logic hit;
        assign hit = wr_en && (sel_idx == 5'(u));

        ipc_mbox_user #(.NQ(NUM_QUEUES)) i_user (
            .clk     (clk),
            .rst_n   (rst_n),
            .new_evt (new_evt),
            .nf_evt  (nf_evt),
            .st_clr  ((hit && sel_kind == RK_STAT) ? wr_data[SW-1:0] : '0),
            .en_set  ((hit && sel_kind == RK_ESET) ? wr_data[SW-1:0] : '0),
            .en_clr  ((hit && sel_kind == RK_ECLR) ? wr_data[SW-1:0] : '0),
            .status  (user_st[u]),
            .enable  (user_en[u]),
            .irq     (irq[u])
        );

        p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[u] |-> (|user_en[u]));

        for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_uq
            p_newmsg_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(push_q[q] && !full_v[q]) |-> user_st[u][2*q]);
        end
    end

    // Read data multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel_kind)
                RK_REV: rd_data = REVISION;
                RK_MSG, RK_FULL, RK_CNT: begin
                    for (int q = 0; q < NUM_QUEUES; q++) begin
                        if (sel_idx == 5'(q)) begin
                            if (sel_kind == RK_MSG)       rd_data = head[q];
                            else if (sel_kind == RK_FULL) rd_data = {31'd0, full_v[q]};
                            else                          rd_data = 32'(cnt[q]);
                        end
                    end
                end
                RK_STAT, RK_ESET, RK_ECLR: begin
                    for (int u = 0; u < NUM_USERS; u++) begin
                        if (sel_idx == 5'(u)) begin
                            rd_data = (sel_kind == RK_STAT) ? 32'(user_st[u]) : 32'(user_en[u]);
                        end
                    end
                end
                default: rd_data = '0;
            endcase
        end
    end

    p_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
    localparam int NQ = 8, NU = 3, DEPTH = 4, AW = 9;
    localparam logic [31:0] REV = 32'h0001_0200;
    localparam logic [31:0] SMASK = 32'h0000_FFFF;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]   wr_data = '0, rd_data;
    logic [NU-1:0] irq;

    always #2.5 clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    // Reference model state
    logic [31:0] mq [NQ][$];
    logic [31:0] m_st [NU];
    logic [31:0] m_en [NU];
    int checks = 0, errors = 0;

    function automatic int a_msg(int m);  return 'h040 + 4*m; endfunction
    function automatic int a_full(int m); return 'h080 + 4*m; endfunction
    function automatic int a_cnt(int m);  return 'h0C0 + 4*m; endfunction
    function automatic int a_st(int u);   return 'h104 + 16*u; endfunction
    function automatic int a_es(int u);   return 'h108 + 16*u; endfunction
    function automatic int a_ec(int u);   return 'h10C + 16*u; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int a);
        for (int m = 0; m < NQ; m++) begin
            if (a == a_msg(m))  return (mq[m].size() > 0) ? mq[m][0] : 32'd0;
            if (a == a_full(m)) return (mq[m].size() == DEPTH) ? 32'd1 : 32'd0;
            if (a == a_cnt(m))  return 32'(mq[m].size());
        end
        for (int u = 0; u < NU; u++) begin
            if (a == a_st(u)) return m_st[u];
            if (a == a_es(u) || a == a_ec(u)) return m_en[u];
        end
        if (a == 0) return REV;
        return 32'd0;
    endfunction

    task automatic model_step(bit wr, bit rd, int a, logic [31:0] d);
        int  cnt [NQ];
        bit  psh [NQ];
        bit  pp  [NQ];
        logic [31:0] set, clr;
        for (int m = 0; m < NQ; m++) begin
            cnt[m] = mq[m].size();
            psh[m] = wr && a == a_msg(m) && cnt[m] < DEPTH;
            pp[m]  = rd && a == a_msg(m) && cnt[m] > 0;
        end
        for (int u = 0; u < NU; u++) begin
            set = '0;
            for (int m = 0; m < NQ; m++) begin
                set[2*m]   = psh[m] || cnt[m] != 0;
                set[2*m+1] = pp[m] && cnt[m] == DEPTH;
            end
            clr = (wr && a == a_st(u)) ? (d & SMASK) : 32'd0;
            m_st[u] = (m_st[u] | set) & ~clr & SMASK;
            if (wr && a == a_es(u)) m_en[u] = m_en[u] | (d & SMASK);
            if (wr && a == a_ec(u)) m_en[u] = m_en[u] & ~(d & SMASK);
        end
        for (int m = 0; m < NQ; m++) begin
            if (psh[m]) mq[m].push_back(d);
            if (pp[m])  void'(mq[m].pop_front());
        end
    endtask

    // One bus cycle; entered and left at a falling edge
    task automatic op(bit wr, bit rd, int a, logic [31:0] d, string req);
        logic [NU-1:0] exp_irq;
        wr_en = wr; rd_en = rd; addr = AW'(a); wr_data = d;
        #1;
        if (rd) chk(req, rd_data, model_read(a));
        for (int u = 0; u < NU; u++) exp_irq[u] = |(m_st[u] & m_en[u]);
        chk("R9 irq", 32'(irq), 32'(exp_irq));
        @(posedge clk);
        model_step(wr, rd, a, d);
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d); op(1, 0, a, d, ""); endtask
    task automatic rd(int a, string req); op(0, 1, a, 0, req); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) op(0, 0, 0, 0, ""); endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        for (int u = 0; u < NU; u++) begin m_st[u] = 0; m_en[u] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", 32'(irq), 32'd0);
        rd(a_cnt(0), "R1 count");
        rd(a_full(3), "R1 full");
        for (int u = 0; u < NU; u++) begin
            rd(a_st(u), "R1 status");
            rd(a_es(u), "R1 enable");
        end
        // R10: revision is read-only, unmapped reads zero
        rd(0, "R10 rev");
        wr(0, 32'hDEAD_BEEF);
        rd(0, "R10 rev after write");
        rd('h020, "R10 unmapped");
        // R2/R5/R11: push three words to queue 0
        for (int i = 0; i < 3; i++) wr(a_msg(0), 32'hA000_0000 + i);
        rd(a_cnt(0), "R2 count");
        rd(a_st(2), "R5 R11 status all users");
        wr(a_es(1), 32'h1);
        rd(a_es(1), "R8 enable set");
        idle(1);
        // R2: ordered pops
        for (int i = 0; i < 3; i++) rd(a_msg(0), "R2 fifo order");
        rd(a_cnt(0), "R2 count after pops");
        rd(a_st(1), "R5 bit after drain");
        wr(a_st(1), 32'h1);
        rd(a_st(1), "R7 cleared");
        // R3: overfill queue 2
        for (int i = 0; i < 5; i++) wr(a_msg(2), 32'hB200_0000 + i);
        rd(a_full(2), "R3 full flag");
        rd(a_cnt(2), "R3 count capped");
        wr(a_es(0), 32'h0000_0020);
        rd(a_st(0), "R6 no not-full yet");
        rd(a_msg(2), "R3 first word");
        rd(a_st(0), "R6 not-full set");
        rd(a_full(2), "R3 no longer full");
        for (int i = 0; i < 3; i++) rd(a_msg(2), "R3 remaining words");
        rd(a_st(2), "R6 R11 bits");
        // R4: read of empty queue
        rd(a_msg(2), "R4 empty read");
        rd(a_cnt(2), "R4 count unchanged");
        // R7: write zero has no effect, then clear not-full
        wr(a_st(0), 32'h0);
        rd(a_st(0), "R7 write zero");
        wr(a_st(0), 32'h0000_0030);
        rd(a_st(0), "R7 w1c");
        // R5: clear while non-empty sets again
        wr(a_msg(5), 32'hC500_0001);
        wr(a_es(2), 32'h0000_0400);
        wr(a_st(2), 32'h0000_0400);
        rd(a_st(2), "R5 cleared one cycle");
        rd(a_st(2), "R5 set again");
        // R8: enable clear
        wr(a_es(2), 32'h0000_FFFF);
        wr(a_ec(2), 32'h0000_0F0F);
        rd(a_ec(2), "R8 enable clear readback");
        rd(a_es(2), "R8 enable set readback");
        // R11: interleaved queues
        wr(a_msg(7), 32'hC700_0000);
        wr(a_msg(1), 32'hC100_0000);
        rd(a_msg(7), "R11 queue 7");
        rd(a_msg(5), "R11 queue 5");
        rd(a_msg(1), "R11 queue 1");
        for (int u = 0; u < NU; u++) wr(a_st(u), 32'hFFFF);
        rd(a_st(1), "R7 R11 all cleared");
        wr(a_ec(2), 32'hFFFF);
        idle(2);
        summary();
    end
endmodule